// File: doc/BRIEF.md
# Mailbox Attribute Command Responder

This block is the target end of an indirect attribute mailbox. A host reaches per-lane attributes through two words on a small memory-mapped slave: a command word that it writes and a status word that it polls. Each command carries an 8-bit opcode in its low byte and a 16-bit argument in its upper half. Bit 15 is the request flag.

Every access follows a four-phase exchange. The host writes the command with the request flag set and polls status until the acknowledge flag (status bit 15) reads 1. It then writes the command again with the request flag clear and polls until the acknowledge flag reads 0. Write-type opcodes drive a serial loopback switch and the controls of a PRBS bit-error test engine. Read-type opcodes capture lane-ready flags, the test state or a slice of the 32-bit error count into status bits 31:16. Those bits keep the captured value until the host clears the request.

Top module: `attr_mailbox_resp`

## Requirements
- R1: After reset the status word, the command readback and all control outputs are 0.
- R2: The command word is at address 0x9003C and the status word at 0x90040. Reading 0x9003C returns the last word written there. Any other address reads 0, and writes to any other address start nothing.
- R3: The acknowledge flag (status bit 15) rises exactly ACK_LAT clock edges after the edge that accepts a request. Status bit 14 (busy) is 1 from acceptance until that edge and reads 0 while the acknowledge flag is 1.
- R4: While the acknowledge flag is 1, a command write with bit 15 clear drops the acknowledge flag and zeroes status bits 31:16 at the next edge.
- R5: A request write is ignored while an exchange is busy or acknowledged. A write with bit 15 clear is ignored while idle.
- R6: Opcode 0x40 sets the loopback output to command bit 17 when it is acknowledged.
- R7: Opcode 0x0D returns the lane-ready inputs, with lane n in status bit 16+n.
- R8: Opcode 0x49 returns the 2-bit test state in status bits 25:24.
- R9: Opcodes 0x4A, 0x4B and 0x4C return error-count bits 11:0 in status 27:16, bits 27:12 in status 31:16, and bits 31:28 in status 19:16.
- R10: Opcode 0x0F with command bits 23:16 equal to 0x20, 0x21 or 0x23 gives a one-cycle pulse on start, stop or inject respectively. The pulse falls in the cycle the acknowledge flag rises.
- R11: Opcode 0x41 loads the pattern select from command bits 31:16. Opcode 0x42 loads the inject count from bits 31:16. Opcode 0x45 loads the counter setup from bits 23:16.
- R12: An unrecognised opcode still completes the exchange with status bits 31:16 equal to 0 and no control output change.
- R13: Status bits 31:16 stay stable while the acknowledge flag is 1, even when the sampled inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the address |
| lane_rdy | input | LANES | Per-lane ready flags |
| bert_state | input | 2 | Test engine state |
| bert_errs | input | 32 | Test engine error count |
| lpbk_en | output | 1 | Serial loopback enable |
| pat_sel | output | 16 | Pattern select |
| inj_count | output | 16 | Number of errors to inject |
| cnt_cfg | output | 8 | Error counter setup |
| bert_start | output | 1 | Start pulse |
| bert_stop | output | 1 | Stop pulse |
| bert_inject | output | 1 | Inject pulse |

## Verification
A behavioural model of the exchange is stepped with the clock, and each output is compared against it on every edge. Several traffic patterns are applied. Clean set/clear exchanges for each opcode class confirm the decode and where each field lands. A distinctive error count (0xABCD1234) separates the three count slices, so a shifted or overlapping slice shows up. Writes placed inside the busy window and the acknowledged window, clears sent while idle, and writes to a neighbouring address confirm that the handshake cannot be re-entered. Changing the lane flags while the acknowledge flag is held shows that the returned data is captured once rather than followed live.

// File: rtl/attr_mb_pkg.sv
package attr_mb_pkg;
  localparam int WORD_W   = 32;
  localparam int REQ_BIT  = 15;

  localparam logic [7:0] OP_LPBK    = 8'h40;
  localparam logic [7:0] OP_READY   = 8'h0D;
  localparam logic [7:0] OP_TSTATE  = 8'h49;
  localparam logic [7:0] OP_CNT_LO  = 8'h4A;
  localparam logic [7:0] OP_CNT_MID = 8'h4B;
  localparam logic [7:0] OP_CNT_HI  = 8'h4C;
  localparam logic [7:0] OP_BERT    = 8'h0F;
  localparam logic [7:0] OP_PATTERN = 8'h41;
  localparam logic [7:0] OP_INJECT  = 8'h42;
  localparam logic [7:0] OP_CNTCFG  = 8'h45;

  localparam logic [7:0] BERT_GO    = 8'h20;
  localparam logic [7:0] BERT_HALT  = 8'h21;
  localparam logic [7:0] BERT_INJ   = 8'h23;

  typedef enum logic [1:0] {HS_IDLE, HS_WAIT, HS_DONE} hs_state_e;

  // Data captured into the upper half of the status word for read opcodes.
  function automatic logic [15:0] read_slice(input logic [7:0]  op,
                                             input logic [15:0] ready,
                                             input logic [1:0]  tstate,
                                             input logic [31:0] errs);
    logic [15:0] r;
    case (op)
      OP_READY:   r = ready;
      OP_TSTATE:  r = {6'b0, tstate, 8'b0};
      OP_CNT_LO:  r = {4'b0, errs[11:0]};
      OP_CNT_MID: r = errs[27:12];
      OP_CNT_HI:  r = {12'b0, errs[31:28]};
      default:    r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input logic [15:0] data,
                                                    input logic ack,
                                                    input logic busy);
    return {data, ack, busy, 14'b0};
  endfunction
endpackage

// File: rtl/mb_bus_port.sv
module mb_bus_port
  import attr_mb_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(20'h9003C),
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(20'h90040)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] status,
  output logic              cmd_wr,
  output logic [WORD_W-1:0] bus_rdata
);
  logic [WORD_W-1:0] cmd_shadow;

  assign cmd_wr = bus_wr && (bus_addr == CMD_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)      cmd_shadow <= '0;
    else if (cmd_wr) cmd_shadow <= bus_wdata;
  end

  always_comb begin
    if (bus_addr == CMD_ADDR)       bus_rdata = cmd_shadow;
    else if (bus_addr == STAT_ADDR) bus_rdata = status;
    else                            bus_rdata = '0;
  end
endmodule

// File: rtl/mb_handshake.sv
module mb_handshake
  import attr_mb_pkg::*;
#(
  parameter int ACK_LAT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic        cmd_req,
  input  logic [7:0]  cmd_op,
  input  logic [15:0] cmd_arg,
  output logic        busy,
  output logic        ack,
  output logic        exec_fire,
  output logic        clear_fire,
  output logic [7:0]  op_q,
  output logic [15:0] arg_q
);
  localparam int CNT_W = $clog2(ACK_LAT) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACK_LAT - 1);

  hs_state_e        state;
  logic [CNT_W-1:0] wait_cnt;

  assign busy       = (state == HS_WAIT);
  assign ack        = (state == HS_DONE);
  assign exec_fire  = busy && (wait_cnt == LAST);
  assign clear_fire = ack && cmd_wr && !cmd_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= HS_IDLE;
      wait_cnt <= '0;
      op_q     <= '0;
      arg_q    <= '0;
    end else begin
      case (state)
        HS_IDLE: if (cmd_wr && cmd_req) begin
          state    <= HS_WAIT;
          wait_cnt <= '0;
          op_q     <= cmd_op;
          arg_q    <= cmd_arg;
        end
        HS_WAIT: if (exec_fire) state <= HS_DONE;
                 else           wait_cnt <= wait_cnt + 1'b1;
        HS_DONE: if (clear_fire) state <= HS_IDLE;
        default: state <= HS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mb_cmd_exec.sv
module mb_cmd_exec
  import attr_mb_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_fire,
  input  logic             clear_fire,
  input  logic [7:0]       op,
  input  logic [15:0]      arg,
  input  logic [LANES-1:0] lane_rdy,
  input  logic [1:0]       bert_state,
  input  logic [31:0]      bert_errs,
  output logic [15:0]      data_q,
  output logic             lpbk_en,
  output logic [15:0]      pat_sel,
  output logic [15:0]      inj_count,
  output logic [7:0]       cnt_cfg,
  output logic             bert_start,
  output logic             bert_stop,
  output logic             bert_inject
);
  logic [15:0] ready_ext;

  if (LANES < 16) begin : g_pad
    assign ready_ext = {{(16-LANES){1'b0}}, lane_rdy};
  end else begin : g_full
    assign ready_ext = lane_rdy;
  end

  logic is_bert;
  assign is_bert = exec_fire && (op == OP_BERT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q      <= '0;
      lpbk_en     <= 1'b0;
      pat_sel     <= '0;
      inj_count   <= '0;
      cnt_cfg     <= '0;
      bert_start  <= 1'b0;
      bert_stop   <= 1'b0;
      bert_inject <= 1'b0;
    end else begin
      bert_start  <= is_bert && (arg[7:0] == BERT_GO);
      bert_stop   <= is_bert && (arg[7:0] == BERT_HALT);
      bert_inject <= is_bert && (arg[7:0] == BERT_INJ);
      if (exec_fire) begin
        data_q <= read_slice(op, ready_ext, bert_state, bert_errs);
        case (op)
          OP_LPBK:    lpbk_en   <= arg[1];
          OP_PATTERN: pat_sel   <= arg;
          OP_INJECT:  inj_count <= arg;
          OP_CNTCFG:  cnt_cfg   <= arg[7:0];
          default: ;
        endcase
      end else if (clear_fire) begin
        data_q <= '0;
      end
    end
  end
endmodule

// File: rtl/attr_mailbox_resp.sv
module attr_mailbox_resp
  import attr_mb_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(20'h9003C),
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(20'h90040),
  parameter int LANES   = 4,
  parameter int ACK_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [LANES-1:0]  lane_rdy,
  input  logic [1:0]        bert_state,
  input  logic [31:0]       bert_errs,
  output logic              lpbk_en,
  output logic [15:0]       pat_sel,
  output logic [15:0]       inj_count,
  output logic [7:0]        cnt_cfg,
  output logic              bert_start,
  output logic              bert_stop,
  output logic              bert_inject
);
  // Named internal events, visible to the bound checker.
  logic        cmd_wr;
  logic        hs_busy;
  logic        hs_ack;
  logic        exec_fire;
  logic        clear_fire;
  logic [7:0]  op_q;
  logic [15:0] arg_q;
  logic [15:0] ret_data;
  logic [31:0] status;

  assign status = status_word(ret_data, hs_ack, hs_busy);

  mb_bus_port #(
    .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .status(status), .cmd_wr(cmd_wr),
    .bus_rdata(bus_rdata)
  );

  mb_handshake #(.ACK_LAT(ACK_LAT)) u_hs (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr),
    .cmd_req(bus_wdata[REQ_BIT]), .cmd_op(bus_wdata[7:0]),
    .cmd_arg(bus_wdata[31:16]), .busy(hs_busy), .ack(hs_ack),
    .exec_fire(exec_fire), .clear_fire(clear_fire),
    .op_q(op_q), .arg_q(arg_q)
  );

  mb_cmd_exec #(.LANES(LANES)) u_exec (
    .clk(clk), .rst_n(rst_n), .exec_fire(exec_fire),
    .clear_fire(clear_fire), .op(op_q), .arg(arg_q),
    .lane_rdy(lane_rdy), .bert_state(bert_state), .bert_errs(bert_errs),
    .data_q(ret_data), .lpbk_en(lpbk_en), .pat_sel(pat_sel),
    .inj_count(inj_count), .cnt_cfg(cnt_cfg), .bert_start(bert_start),
    .bert_stop(bert_stop), .bert_inject(bert_inject)
  );
endmodule

// File: rtl/mb_resp_checker.sv
module mb_resp_checker #(
  parameter int ACK_LAT = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        ack,
  input logic [15:0] data,
  input logic        lpbk,
  input logic        start,
  input logic        stop,
  input logic        inject
);
  localparam int CW = $clog2(ACK_LAT + 2) + 1;
  logic [CW-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    lat_cnt <= '0;
    else if (busy) lat_cnt <= lat_cnt + 1'b1;
    else           lat_cnt <= '0;
  end

  p_busy_ack_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && ack));
  p_ack_from_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(busy));
  p_ack_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> (lat_cnt == CW'(ACK_LAT)));
  p_data_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (data == 16'h0));
  p_lpbk_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lpbk) |-> $rose(ack));
  p_pulse_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start, stop, inject}));
  p_pulse_on_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start || stop || inject) |-> $rose(ack));
  p_data_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && $past(ack)) |-> $stable(data));
endmodule

bind attr_mailbox_resp mb_resp_checker #(.ACK_LAT(ACK_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(hs_busy), .ack(hs_ack), .data(ret_data),
  .lpbk(lpbk_en), .start(bert_start), .stop(bert_stop), .inject(bert_inject)
);

// File: tb/test_attr_mailbox_resp.sv
`timescale 1ns/1ps
module test_attr_mailbox_resp;
  localparam int LAT = 3;
  localparam logic [19:0] CMD = 20'h9003C;
  localparam logic [19:0] STA = 20'h90040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        bus_wr = 1'b0;
  logic [19:0] bus_addr = STA;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  lane_rdy = '0;
  logic [1:0]  bert_state = '0;
  logic [31:0] bert_errs = '0;
  logic        lpbk_en, bert_start, bert_stop, bert_inject;
  logic [15:0] pat_sel, inj_count;
  logic [7:0]  cnt_cfg;

  attr_mailbox_resp #(.ACK_LAT(LAT)) i_attr_mailbox_resp (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lane_rdy(lane_rdy),
    .bert_state(bert_state), .bert_errs(bert_errs), .lpbk_en(lpbk_en),
    .pat_sel(pat_sel), .inj_count(inj_count), .cnt_cfg(cnt_cfg),
    .bert_start(bert_start), .bert_stop(bert_stop), .bert_inject(bert_inject)
  );

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model: 0 idle, 1 waiting, 2 acknowledged
  int          m_st = 0, m_cnt = 0;
  longint      m_op = 0, m_last = 0, m_data = 0, m_pat = 0, m_inj = 0, m_cfg = 0;
  int          m_lpbk = 0, m_go = 0, m_halt = 0, m_ij = 0;
  int          n_go = 0, n_halt = 0, n_ij = 0;

  function automatic longint m_status();
    return m_data * 65536 + (m_st == 2 ? 32768 : 0) + (m_st == 1 ? 16384 : 0);
  endfunction

  task automatic m_execute();
    longint opc, a;
    opc = m_op % 256;
    a = m_op / 65536;
    m_data = 0;
    if (opc == 'h0D) m_data = lane_rdy;
    else if (opc == 'h49) m_data = bert_state * 256;
    else if (opc == 'h4A) m_data = bert_errs % 4096;
    else if (opc == 'h4B) m_data = (bert_errs / 4096) % 65536;
    else if (opc == 'h4C) m_data = bert_errs / (longint'(1) << 28);
    else if (opc == 'h40) m_lpbk = int'((a / 2) % 2);
    else if (opc == 'h41) m_pat = a;
    else if (opc == 'h42) m_inj = a;
    else if (opc == 'h45) m_cfg = a % 256;
    else if (opc == 'h0F) begin
      if (a % 256 == 'h20) m_go = 1;
      if (a % 256 == 'h21) m_halt = 1;
      if (a % 256 == 'h23) m_ij = 1;
    end
  endtask

  always @(posedge clk) begin
    logic wr_cmd;
    longint exp_rd;
    if (bert_start)  n_go++;
    if (bert_stop)   n_halt++;
    if (bert_inject) n_ij++;
    wr_cmd = bus_wr && (bus_addr == CMD);
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_op = 0; m_last = 0; m_data = 0;
      m_pat = 0; m_inj = 0; m_cfg = 0; m_lpbk = 0;
      m_go = 0; m_halt = 0; m_ij = 0;
    end else begin
      m_go = 0; m_halt = 0; m_ij = 0;
      if (m_st == 0) begin
        if (wr_cmd && bus_wdata[15]) begin
          m_op = bus_wdata; m_st = 1; m_cnt = 0;
        end
      end else if (m_st == 1) begin
        if (m_cnt == LAT - 1) begin m_st = 2; m_execute(); end
        else m_cnt++;
      end else begin
        if (wr_cmd && !bus_wdata[15]) begin m_st = 0; m_data = 0; end
      end
      if (wr_cmd) m_last = bus_wdata;
    end
    #1;
    if (bus_addr == CMD) exp_rd = m_last;
    else if (bus_addr == STA) exp_rd = m_status();
    else exp_rd = 0;
    chk(cur_tag, bus_rdata, exp_rd);
    chk("R6 lpbk", lpbk_en, m_lpbk);
    chk("R11 pat", pat_sel, m_pat);
    chk("R11 inj", inj_count, m_inj);
    chk("R11 cfg", cnt_cfg, m_cfg);
    chk("R10 pulses", {bert_start, bert_stop, bert_inject}, m_go * 4 + m_halt * 2 + m_ij);
  end

  task automatic mb_write(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = STA;
    #1;
  endtask

  task automatic hs_req(input logic [31:0] c, output logic [15:0] d, output int lat);
    mb_write(CMD, c | 32'h8000);
    chk("R3 busy after accept", bus_rdata[15:14], 2'b01);
    lat = 0;
    while (bus_rdata[15] !== 1'b1 && lat < 40) begin
      @(negedge clk); #1; lat++;
    end
    chk("R3 busy low with ack", bus_rdata[14], 0);
    d = bus_rdata[31:16];
  endtask

  task automatic hs_clr(input logic [31:0] c);
    mb_write(CMD, c & ~32'h8000);
    chk("R4 ack dropped", bus_rdata[15], 0);
    chk("R4 data cleared", bus_rdata[31:16], 0);
  endtask

  task automatic hs(input logic [31:0] c, output logic [15:0] d);
    int lat;
    hs_req(c, d, lat);
    chk("R3 latency", lat, LAT);
    hs_clr(c);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    int lat;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 status", bus_rdata, 0);
    chk("R1 outputs", {lpbk_en, pat_sel, inj_count, cnt_cfg}, 0);
    rst_n = 1'b1;
    bus_addr = CMD; #1;
    chk("R1 cmd readback", bus_rdata, 0);
    bus_addr = STA;

    cur_tag = "R6";
    hs(32'h0006A040, d);
    chk("R6 loopback on", lpbk_en, 1);
    hs(32'h00000040, d);
    chk("R6 loopback off", lpbk_en, 0);

    cur_tag = "R7";
    lane_rdy = 4'b1010;
    hs(32'h0000000D, d);
    chk("R7 lane flags", d, 16'h000A);

    cur_tag = "R13";
    hs_req(32'h0000000D, d, lat);
    lane_rdy = 4'b0101;
    repeat (3) @(negedge clk);
    #1;
    chk("R13 held data", bus_rdata[31:16], 16'h000A);
    hs_clr(32'h0000000D);

    cur_tag = "R8";
    bert_state = 2'd1;
    hs(32'h00000049, d);
    chk("R8 state running", d, 16'h0100);
    bert_state = 2'd3;
    hs(32'h00000049, d);
    chk("R8 state done", d, 16'h0300);

    cur_tag = "R9";
    bert_errs = 32'hABCD1234;
    hs(32'h0000004A, d);
    chk("R9 low slice", d, 16'h0234);
    hs(32'h0000004B, d);
    chk("R9 middle slice", d, 16'hBCD1);
    hs(32'h0000004C, d);
    chk("R9 top slice", d, 16'h000A);

    cur_tag = "R11";
    hs(32'h030C2041, d);
    chk("R11 pattern", pat_sel, 16'h030C);
    hs(32'h01232042, d);
    chk("R11 inject count", inj_count, 16'h0123);
    hs(32'h00142045, d);
    chk("R11 counter setup", cnt_cfg, 8'h14);

    cur_tag = "R10";
    hs(32'h0020200F, d);
    chk("R10 start count", n_go, 1);
    hs(32'h0023200F, d);
    chk("R10 inject pulse count", n_ij, 1);
    hs(32'h0021200F, d);
    chk("R10 stop count", n_halt, 1);
    hs(32'h00002041, d);
    chk("R11 pattern cleared", pat_sel, 0);

    cur_tag = "R12";
    hs(32'h0006A077, d);
    chk("R12 unknown data", d, 0);
    chk("R12 outputs kept", {lpbk_en, inj_count, cnt_cfg}, {1'b0, 16'h0123, 8'h14});

    cur_tag = "R5";
    mb_write(CMD, 32'h0000800D);
    mb_write(CMD, 32'h00008049);
    while (bus_rdata[15] !== 1'b1) begin @(negedge clk); #1; end
    chk("R5 first request wins", bus_rdata[31:16], 16'h0005);
    mb_write(CMD, 32'h0000804A);
    chk("R5 request during ack", bus_rdata[31:15], {16'h0005, 1'b1});
    hs_clr(32'h0000000D);
    mb_write(CMD, 32'h00000049);
    repeat (LAT + 1) @(negedge clk);
    #1;
    chk("R5 idle clear ignored", bus_rdata, 0);

    cur_tag = "R2";
    mb_write(20'h90044, 32'h0000800D);
    repeat (LAT + 1) @(negedge clk);
    #1;
    chk("R2 other address no request", bus_rdata, 0);
    bus_addr = 20'h90044; #1;
    chk("R2 other address reads zero", bus_rdata, 0);
    bus_addr = CMD; #1;
    chk("R2 cmd readback", bus_rdata, 32'h00000049);
    bus_addr = STA;

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule